// File: doc/BRIEF.md
# 8-bit Add/Subtract/Compare Flag ALU

This block is the arithmetic slice of a small 8-bit processor datapath. The caller supplies two operands and a carry. The first operand is the accumulator side and the second is the memory side. The caller also supplies an operation code and a one-cycle strobe. On the clock edge where the strobe is high, the block registers an 8-bit result and updates five status flags: negative, zero, carry, signed overflow and half carry.

Subtraction reuses the adder. The second operand is inverted and the incoming carry acts as "no borrow". Compare performs a subtraction with a forced carry of one. It refreshes only negative, zero and carry, and it never requests a result write. A separate clear input drops the overflow and half-carry flags together. The caller decides where the result is stored, qualified by the write-enable output.

Top module: `addsub_flag_alu`

## Requirements
- R1: With op_i = 2'b00 (add), the registered result is (a_i + b_i + carry_i) mod 256, and c_o takes bit 8 of that 9-bit sum.
- R2: With op_i = 2'b01 (subtract), the block adds a_i, the bitwise inverse of b_i and carry_i. The result is that sum mod 256 and c_o is its bit 8, so c_o = 1 means no borrow.
- R3: For add and subtract, h_o is the carry out of bit 3 of the addition, using the inverted second operand for subtract.
- R4: For add and subtract, v_o is set when both addend operands (the second one after any inversion) have the same bit 7 and the result's bit 7 differs from it.
- R5: For every valid operation, n_o equals bit 7 of the computed 8-bit value and z_o is set when that value is zero.
- R6: With op_i = 2'b10 (compare), the block computes a_i - b_i and ignores carry_i. c_o is set when a_i >= b_i unsigned. v_o and h_o keep their values, res_o is unchanged and res_we_o stays low.
- R7: res_we_o is high for exactly the one cycle after an add or subtract strobe, and res_o then holds that operation's result.
- R8: Without op_valid_i, no flag and no result changes, except through clr_vh_i.
- R9: clr_vh_i clears v_o and h_o on the next edge and leaves n_o, z_o, c_o and res_o alone. When it coincides with an add or subtract strobe, the arithmetic values of v_o and h_o win.
- R10: op_i = 2'b11 is a no-operation: a strobe with it changes no flag or result and raises no write-enable.
- R11: Asynchronous reset (rst_ni low) clears res_o, res_we_o and all five flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | 00 add, 01 subtract, 10 compare, 11 none |
| a_i | input | 8 | Accumulator-side operand |
| b_i | input | 8 | Memory-side operand |
| carry_i | input | 1 | Carry in (no-borrow for subtract) |
| clr_vh_i | input | 1 | Clear overflow and half-carry flags |
| res_o | output | 8 | Registered result |
| res_we_o | output | 1 | Result write-enable pulse |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Overflow flag |
| h_o | output | 1 | Half-carry flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |

## Verification
Every output is one register stage from its inputs. The result, write-enable and all five flags reflect a strobe on the first rising edge that sees it. The write-enable must fall again on the following edge. The bench drives inputs on the falling edge, lets one rising edge pass, and checks at the next falling edge. One further falling edge is used to confirm the write pulse has ended and that held flags did not drift. Compare cases in the vector table carry the overflow and half-carry values left by the previous vector, so retention is checked along the sequence.

// File: rtl/addsub_alu_pkg.sv
package addsub_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_CMP  = 2'b10,
    OP_NONE = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic h;
    logic z;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
  import addsub_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] b_eff_o,
  output logic              cin_eff_o,
  output logic              is_arith_o,
  output logic              is_cmp_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  always_comb begin
    b_eff_o    = b_i;
    cin_eff_o  = carry_i;
    is_arith_o = 1'b0;
    is_cmp_o   = 1'b0;
    unique case (op)
      OP_ADD: is_arith_o = 1'b1;
      OP_SUB: begin
        b_eff_o    = ~b_i;
        is_arith_o = 1'b1;
      end
      OP_CMP: begin
        // a - b as a + ~b + 1, incoming carry ignored
        b_eff_o   = ~b_i;
        cin_eff_o = 1'b1;
        is_cmp_o  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_sum_core.sv
module alu_sum_core #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              half_o,
  output logic              ovf_o
);
  localparam int LO_W = DATA_W / 2;
  localparam int HI_W = DATA_W - LO_W;

  logic [LO_W:0] lo_sum;
  logic [HI_W:0] hi_sum;

  // two-nibble chain exposes the half carry directly
  assign lo_sum = {1'b0, a_i[LO_W-1:0]} + {1'b0, b_i[LO_W-1:0]} + {{LO_W{1'b0}}, cin_i};
  assign hi_sum = {1'b0, a_i[DATA_W-1:LO_W]} + {1'b0, b_i[DATA_W-1:LO_W]}
                + {{HI_W{1'b0}}, lo_sum[LO_W]};

  assign sum_o  = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
  assign cout_o = hi_sum[HI_W];
  assign half_o = lo_sum[LO_W];
  assign ovf_o  = (a_i[DATA_W-1] == b_i[DATA_W-1]) && (sum_o[DATA_W-1] != a_i[DATA_W-1]);
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import addsub_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              is_arith_i,
  input  logic              is_cmp_i,
  input  logic              clr_vh_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic              cout_i,
  input  logic              half_i,
  input  logic              ovf_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_we_o,
  output alu_flags_t        flags_o
);
  logic do_arith, do_cmp, sum_zero;

  assign do_arith = valid_i && is_arith_i;
  assign do_cmp   = valid_i && is_cmp_i;
  assign sum_zero = (sum_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o    <= '0;
      res_we_o <= 1'b0;
      flags_o  <= '0;
    end else begin
      res_we_o <= do_arith;
      if (do_arith) res_o <= sum_i;

      if (do_arith || do_cmp) begin
        flags_o.n <= sum_i[DATA_W-1];
        flags_o.z <= sum_zero;
        flags_o.c <= cout_i;
      end

      if (do_arith) begin
        flags_o.v <= ovf_i;
        flags_o.h <= half_i;
      end else if (clr_vh_i) begin
        flags_o.v <= 1'b0;
        flags_o.h <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/addsub_flag_alu.sv
module addsub_flag_alu
  import addsub_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  input  logic              clr_vh_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_we_o,
  output logic              n_o,
  output logic              v_o,
  output logic              h_o,
  output logic              z_o,
  output logic              c_o
);
  logic [DATA_W-1:0] b_eff, sum;
  logic              cin_eff, is_arith, is_cmp, cout, half, ovf;
  alu_flags_t        flags;

  alu_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .op_i      (op_i),
    .b_i       (b_i),
    .carry_i   (carry_i),
    .b_eff_o   (b_eff),
    .cin_eff_o (cin_eff),
    .is_arith_o(is_arith),
    .is_cmp_o  (is_cmp)
  );

  alu_sum_core #(.DATA_W(DATA_W)) u_sum (
    .a_i   (a_i),
    .b_i   (b_eff),
    .cin_i (cin_eff),
    .sum_o (sum),
    .cout_o(cout),
    .half_o(half),
    .ovf_o (ovf)
  );

  alu_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (op_valid_i),
    .is_arith_i(is_arith),
    .is_cmp_i  (is_cmp),
    .clr_vh_i  (clr_vh_i),
    .sum_i     (sum),
    .cout_i    (cout),
    .half_i    (half),
    .ovf_i     (ovf),
    .res_o     (res_o),
    .res_we_o  (res_we_o),
    .flags_o   (flags)
  );

  assign n_o = flags.n;
  assign v_o = flags.v;
  assign h_o = flags.h;
  assign z_o = flags.z;
  assign c_o = flags.c;
endmodule

// File: rtl/addsub_flag_alu_chk.sv
module addsub_flag_alu_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              carry_i,
  input logic              clr_vh_i,
  input logic [DATA_W-1:0] res_o,
  input logic              res_we_o,
  input logic              n_o,
  input logic              v_o,
  input logic              h_o,
  input logic              z_o,
  input logic              c_o
);
  logic arith_stb, cmp_stb;
  assign arith_stb = op_valid_i && (op_i == 2'b00 || op_i == 2'b01);
  assign cmp_stb   = op_valid_i && (op_i == 2'b10);

  AST_ADD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 2'b00) |=>
      res_o == DATA_W'($past(a_i) + $past(b_i) + DATA_W'($past(carry_i)))); // R1

  AST_SUB_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 2'b01) |=>
      res_o == DATA_W'($past(a_i) + ~$past(b_i) + DATA_W'($past(carry_i)))); // R2

  AST_N_FROM_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_o |-> (n_o == res_o[DATA_W-1])); // R5

  AST_Z_FROM_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_o |-> (z_o == (res_o == '0))); // R5

  AST_CMP_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_stb |=> !res_we_o); // R6

  AST_CMP_KEEP_VH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_stb && !clr_vh_i) |=> ($stable(v_o) && $stable(h_o) && $stable(res_o))); // R6

  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arith_stb |=> res_we_o); // R7

  AST_WE_ONLY_ARITH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arith_stb |=> !res_we_o); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i && !clr_vh_i) |=>
      ($stable(n_o) && $stable(v_o) && $stable(h_o) && $stable(z_o) && $stable(c_o)
       && $stable(res_o))); // R8

  AST_CLR_VH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_vh_i && !arith_stb) |=> (!v_o && !h_o)); // R9

  AST_NOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 2'b11 && !clr_vh_i) |=>
      ($stable(n_o) && $stable(z_o) && $stable(c_o) && $stable(v_o) && $stable(h_o))); // R10
endmodule

bind addsub_flag_alu addsub_flag_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/addsub_flag_alu_test.sv
module addsub_flag_alu_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       op_valid_i = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic [7:0] a_i = '0, b_i = '0;
  logic       carry_i = 1'b0, clr_vh_i = 1'b0;
  logic [7:0] res_o;
  logic       res_we_o, n_o, v_o, h_o, z_o, c_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  addsub_flag_alu uut (.*);

  // {op, cin, a, b, exp_res, exp flags n v h z c}
  localparam int NV = 12;
  localparam logic [31:0] VEC [NV] = '{
    {2'b00, 1'b0, 8'h12, 8'h34, 8'h46, 5'b00000},
    {2'b00, 1'b0, 8'h0F, 8'h01, 8'h10, 5'b00100},
    {2'b00, 1'b0, 8'h7F, 8'h01, 8'h80, 5'b11100},
    {2'b00, 1'b0, 8'hFF, 8'h01, 8'h00, 5'b00111},
    {2'b00, 1'b1, 8'h80, 8'h80, 8'h01, 5'b01001},
    {2'b10, 1'b0, 8'h05, 8'h05, 8'h01, 5'b01011},
    {2'b01, 1'b1, 8'h05, 8'h03, 8'h02, 5'b00101},
    {2'b10, 1'b1, 8'h03, 8'h05, 8'h02, 5'b10100},
    {2'b01, 1'b1, 8'h03, 8'h05, 8'hFE, 5'b10000},
    {2'b01, 1'b1, 8'h80, 8'h01, 8'h7F, 5'b01001},
    {2'b01, 1'b0, 8'h00, 8'h00, 8'hFF, 5'b10000},
    {2'b10, 1'b0, 8'hFF, 8'h00, 8'hFF, 5'b10001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] flg();
    return {n_o, v_o, h_o, z_o, c_o};
  endfunction

  task automatic strobe(input logic [1:0] op, input logic cin, input logic [7:0] a,
                        input logic [7:0] b, input logic clr);
    @(negedge clk_i);
    op_valid_i = 1'b1; op_i = op; carry_i = cin; a_i = a; b_i = b; clr_vh_i = clr;
    @(negedge clk_i);
    op_valid_i = 1'b0; clr_vh_i = 1'b0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check("R11 reset res", {24'h0, res_o}, 32'h0);
    check("R11 reset flags/we", {26'h0, res_we_o, flg()}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      strobe(VEC[i][31:30], VEC[i][29], VEC[i][28:21], VEC[i][20:13], 1'b0);
      check($sformatf("R1 R2 R3 R4 R5 R6 vec%0d res", i), {24'h0, res_o}, {24'h0, VEC[i][12:5]});
      check($sformatf("R1 R2 R3 R4 R5 R6 vec%0d flags", i), {27'h0, flg()}, {27'h0, VEC[i][4:0]});
      check($sformatf("R6 R7 vec%0d we", i), {31'h0, res_we_o}, {31'h0, VEC[i][31:30] != 2'b10});
      @(negedge clk_i);
      check($sformatf("R7 vec%0d we drop", i), {31'h0, res_we_o}, 32'h0);
    end

    // R8: inputs change without strobe -> nothing moves (flags 10001, res FF)
    a_i = 8'h01; b_i = 8'h01; op_i = 2'b00; carry_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R8 idle flags", {27'h0, flg()}, {27'h0, 5'b10001});
    check("R8 idle res", {24'h0, res_o}, 32'hFF);

    // R10: reserved op
    strobe(2'b11, 1'b1, 8'h00, 8'h00, 1'b0);
    check("R10 nop flags", {27'h0, flg()}, {27'h0, 5'b10001});
    check("R10 nop res/we", {23'h0, res_we_o, res_o}, {23'h0, 1'b0, 8'hFF});

    // set V and H: 0x7F + 0x01 -> 0x80, flags 11100
    strobe(2'b00, 1'b0, 8'h7F, 8'h01, 1'b0);
    check("R4 setup flags", {27'h0, flg()}, {27'h0, 5'b11100});
    // R9: clear alone
    @(negedge clk_i); clr_vh_i = 1'b1;
    @(negedge clk_i); clr_vh_i = 1'b0;
    check("R9 clear vh", {27'h0, flg()}, {27'h0, 5'b10000});
    check("R9 clear keeps res", {24'h0, res_o}, 32'h80);
    // R9 priority: clear with add strobe, arithmetic V/H win
    strobe(2'b00, 1'b0, 8'h7F, 8'h01, 1'b1);
    check("R9 priority flags", {27'h0, flg()}, {27'h0, 5'b11100});
    // R6 with clear: compare 0x10 vs 0x20 clears V/H, C=0 N=1
    strobe(2'b10, 1'b1, 8'h10, 8'h20, 1'b1);
    check("R6 R9 cmp+clear flags", {27'h0, flg()}, {27'h0, 5'b10000});

    // R11: reset mid-run
    strobe(2'b00, 1'b0, 8'hFF, 8'h01, 1'b0);
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    check("R11 async reset", {23'h0, res_we_o, res_o, 5'h0} | {27'h0, flg()}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule